// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit settles the outcome of a conditional branch for a 32-bit RISC core in one registered step. Each cycle with `in_valid` high it takes an instruction word, the program counter, the count register, the link register and the 32-bit condition register. It then decides whether the branch is taken and produces the next fetch address, the updated count register and the link register value. A 3-bit form code picks one of eight variants. Bits 2:1 of the form code select the target kind: 0 is a PC-relative displacement, 1 is an absolute displacement, 2 is the count register and 3 is the link register. Bit 0 of the form code selects a linking variant.

The 5-bit option field in instruction bits 25:21 controls two tests that can be enabled separately. One decrements the count register and tests it. The other tests one condition bit. Each test has its own polarity. The condition-bit index sits in instruction bits 20:16. The displacement is instruction bits 15:0 with the two low bits cleared, sign-extended to 32 bits. Results appear on the outputs one clock after the request.

Top module: `branch_resolve_unit`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `taken`, `lr_wr`, `next_addr`, `ctr_out` and `lr_out` are all zero.
- R2: For form kind 0, a taken branch targets `pc` plus the sign-extended displacement (instruction bits 15:0 with bits 1:0 forced to zero).
- R3: When option bit 2 (instruction bit 23) is clear and the form kind is not 2, `ctr_out` is `ctr` minus one, wrapping modulo 2^32. Otherwise `ctr_out` equals `ctr`.
- R4: The count test passes when option bit 2 is set. Otherwise it passes when "decremented count is nonzero" equals the inverse of option bit 1 (instruction bit 22). So with bit 1 set, the branch is taken when the count reaches zero. A decrement from zero yields all ones, which counts as nonzero.
- R5: The condition test passes when option bit 4 (instruction bit 25) is set. Otherwise it passes when the condition bit at index instruction[20:16] equals option bit 3 (instruction bit 24). Index 0 selects `cr[31]` and index 31 selects `cr[0]`.
- R6: The branch is taken only when both tests pass. When it is not taken, `next_addr` is `pc + 4`.
- R7: For form kind 1, a taken branch targets the sign-extended displacement itself.
- R8: For form kind 2, the count test is ignored and the count register is never decremented. The target is `ctr` with bits 1:0 forced to zero.
- R9: For form kind 3, both tests and the decrement apply. The target is `lr` with bits 1:0 forced to zero.
- R10: When form bit 0 is set, `lr_wr` is 1 and `lr_out` is `pc + 4`, whether or not the branch is taken. Otherwise `lr_wr` is 0 and `lr_out` equals `lr`.
- R11: For the linking variant of form kind 3, the taken target uses the incoming `lr`, not the newly written `pc + 4`.
- R12: Results appear exactly one cycle after a request. `out_valid` follows `in_valid` by one cycle, and `taken` is high only while `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| form | input | 3 | Variant: [2:1] target kind, [0] link |
| instr | input | 32 | Branch instruction word |
| pc | input | 32 | Address of the branch |
| ctr | input | 32 | Count register value |
| lr | input | 32 | Link register value |
| cr | input | 32 | Condition register |
| out_valid | output | 1 | Result strobe, one cycle after request |
| taken | output | 1 | Branch taken |
| next_addr | output | 32 | Next fetch address |
| ctr_out | output | 32 | Updated count register |
| lr_out | output | 32 | Updated link register |
| lr_wr | output | 1 | Link register written by this variant |

## Verification
The bench targets five corner cases:
- A decrement from zero must wrap to all ones and count as nonzero. A design that saturates instead would branch wrongly.
- The count test must look at the decremented value. Testing the value before the decrement flips the outcome when the count is 1.
- The condition-bit numbering must start from the most significant bit. Reversing it selects the wrong bit for indices 0 and 31.
- The count-target form must neither decrement nor test the count.
- The linking link-target form must jump to the old link value, not to `pc + 4`.

It also covers negative displacements, displacements with their low bits set, and not-taken linking forms that must still write the link register.

// File: rtl/brc_pkg.sv
// Package: shared types and fixed field positions for the branch resolution unit.
// Assumes a 32-bit instruction word with option, index and displacement fields at fixed bits.
package brc_pkg;
    typedef enum logic [1:0] {
        TGT_REL = 2'd0,
        TGT_ABS = 2'd1,
        TGT_CTR = 2'd2,
        TGT_LNK = 2'd3
    } tgt_kind_e;

    localparam int ILEN     = 32;
    localparam int OPT_LSB  = 21;
    localparam int IDX_LSB  = 16;
    localparam int FLD_W    = 5;
    localparam int DISP_W   = 16;

    // option field bit meanings
    localparam int OB_NO_CTR  = 2;
    localparam int OB_ZERO    = 1;
    localparam int OB_NO_COND = 4;
    localparam int OB_SENSE   = 3;
endpackage

// File: rtl/brc_field_decode.sv
// Module: splits the instruction word into option, bit index and a
// sign-extended, word-aligned displacement. Purely combinational.
module brc_field_decode
    import brc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [ILEN-1:0]  instr,
    output logic [FLD_W-1:0] opt,
    output logic [FLD_W-1:0] idx,
    output logic [XLEN-1:0]  disp
);
    localparam logic [DISP_W-1:0] ALIGN_MASK = ~DISP_W'(3);

    logic [DISP_W-1:0] raw_disp;
    logic              unused_hi;

    // Extract fields and align/sign-extend the displacement.
    always_comb begin
        opt      = instr[OPT_LSB +: FLD_W];
        idx      = instr[IDX_LSB +: FLD_W];
        raw_disp = instr[DISP_W-1:0] & ALIGN_MASK;
        disp     = {{(XLEN-DISP_W){raw_disp[DISP_W-1]}}, raw_disp};
    end

    assign unused_hi = ^instr[ILEN-1:OPT_LSB+FLD_W];
endmodule

// File: rtl/brc_decision.sv
// Module: evaluates the count test (with optional decrement) and the
// condition-bit test and combines them into a taken decision.
// Assumes the condition register index 0 is its most significant bit.
module brc_decision
    import brc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CRW  = 32
) (
    input  tgt_kind_e        kind,
    input  logic [FLD_W-1:0] opt,
    input  logic [FLD_W-1:0] idx,
    input  logic [CRW-1:0]   cr,
    input  logic [XLEN-1:0]  ctr,
    output logic [XLEN-1:0]  ctr_next,
    output logic             taken
);
    logic dec_en;
    logic ctr_ok;
    logic cond_ok;
    logic sel_bit;

    // Decrement the count when enabled; the count-target form never decrements.
    always_comb begin
        dec_en   = !opt[OB_NO_CTR] && (kind != TGT_CTR);
        ctr_next = dec_en ? (ctr - XLEN'(1)) : ctr;
    end

    // Count test on the decremented value, selectable polarity.
    always_comb begin
        ctr_ok = opt[OB_NO_CTR] || (kind == TGT_CTR) ||
                 ((ctr_next != '0) == !opt[OB_ZERO]);
    end

    // Condition test on the MSB-first indexed bit.
    always_comb begin
        sel_bit = cr[CRW-1-int'(idx)];
        cond_ok = opt[OB_NO_COND] || (sel_bit == opt[OB_SENSE]);
        taken   = ctr_ok && cond_ok;
    end
endmodule

// File: rtl/brc_target_mux.sv
// Module: chooses the next fetch address from the four target kinds or the
// fall-through address. Uses the incoming link value, before any link write.
module brc_target_mux
    import brc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  tgt_kind_e       kind,
    input  logic            taken,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] disp,
    input  logic [XLEN-1:0] ctr,
    input  logic [XLEN-1:0] lr,
    output logic [XLEN-1:0] fall_addr,
    output logic [XLEN-1:0] next_addr
);
    localparam logic [XLEN-1:0] WORD_MASK = ~XLEN'(3);
    localparam logic [XLEN-1:0] STEP      = XLEN'(4);

    logic [XLEN-1:0] tgt;

    // Compute the target of the selected kind.
    always_comb begin
        unique case (kind)
            TGT_REL: tgt = pc + disp;
            TGT_ABS: tgt = disp;
            TGT_CTR: tgt = ctr & WORD_MASK;
            TGT_LNK: tgt = lr & WORD_MASK;
            default: tgt = pc + disp;
        endcase
    end

    // Pick target or sequential address.
    always_comb begin
        fall_addr = pc + STEP;
        next_addr = taken ? tgt : fall_addr;
    end
endmodule

// File: rtl/branch_resolve_unit.sv
// Module: top of the conditional branch resolution unit. Decodes, decides,
// selects the target and registers all results with one cycle of latency.
// Assumes one request per cycle at most; outputs hold between requests,
// except taken, which drops when no result is presented.
module branch_resolve_unit
    import brc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CRW  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       form,
    input  logic [ILEN-1:0]  instr,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  ctr,
    input  logic [XLEN-1:0]  lr,
    input  logic [CRW-1:0]   cr,
    output logic             out_valid,
    output logic             taken,
    output logic [XLEN-1:0]  next_addr,
    output logic [XLEN-1:0]  ctr_out,
    output logic [XLEN-1:0]  lr_out,
    output logic             lr_wr
);
    tgt_kind_e        kind;
    logic             link;
    logic [FLD_W-1:0] opt;
    logic [FLD_W-1:0] idx;
    logic [XLEN-1:0]  disp;
    logic [XLEN-1:0]  ctr_next;
    logic             tk;
    logic [XLEN-1:0]  fall_addr;
    logic [XLEN-1:0]  nxt;

    // Split the form code into target kind and link flag.
    always_comb begin
        kind = tgt_kind_e'(form[2:1]);
        link = form[0];
    end

    brc_field_decode #(.XLEN(XLEN)) u_dec (
        .instr (instr),
        .opt   (opt),
        .idx   (idx),
        .disp  (disp)
    );

    brc_decision #(.XLEN(XLEN), .CRW(CRW)) u_decide (
        .kind     (kind),
        .opt      (opt),
        .idx      (idx),
        .cr       (cr),
        .ctr      (ctr),
        .ctr_next (ctr_next),
        .taken    (tk)
    );

    brc_target_mux #(.XLEN(XLEN)) u_tgt (
        .kind      (kind),
        .taken     (tk),
        .pc        (pc),
        .disp      (disp),
        .ctr       (ctr),
        .lr        (lr),
        .fall_addr (fall_addr),
        .next_addr (nxt)
    );

    // Register results; taken only accompanies a valid result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            taken     <= 1'b0;
            next_addr <= '0;
            ctr_out   <= '0;
            lr_out    <= '0;
            lr_wr     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            taken     <= in_valid && tk;
            if (in_valid) begin
                next_addr <= nxt;
                ctr_out   <= ctr_next;
                lr_out    <= link ? fall_addr : lr;
                lr_wr     <= link;
            end
        end
    end
endmodule

// File: rtl/brc_checker.sv
// Module: temporal checks for branch_resolve_unit, attached by bind.
module brc_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [2:0]      form,
    input logic            no_dec_bit,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] ctr,
    input logic [XLEN-1:0] lr,
    input logic            out_valid,
    input logic            taken,
    input logic [XLEN-1:0] next_addr,
    input logic [XLEN-1:0] ctr_out,
    input logic [XLEN-1:0] lr_out,
    input logic            lr_wr
);
    p_valid_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_taken_needs_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> out_valid);
    p_fallthrough_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (taken || next_addr == $past(pc) + XLEN'(4)));
    p_link_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && form[0]) |=> (lr_wr && lr_out == $past(pc) + XLEN'(4)));
    p_link_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !form[0]) |=> (!lr_wr && lr_out == $past(lr)));
    p_ctr_form_nodec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && form[2:1] == 2'd2) |=> (ctr_out == $past(ctr)));
    p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && form[2:1] != 2'd2 && !no_dec_bit) |=> (ctr_out == $past(ctr) - XLEN'(1)));
    p_reg_target_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && form[2]) |=> (next_addr[1:0] == 2'b00));
endmodule

bind branch_resolve_unit brc_checker #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .form       (form),
    .no_dec_bit (instr[23]),
    .pc         (pc),
    .ctr        (ctr),
    .lr         (lr),
    .out_valid  (out_valid),
    .taken      (taken),
    .next_addr  (next_addr),
    .ctr_out    (ctr_out),
    .lr_out     (lr_out),
    .lr_wr      (lr_wr)
);

// File: tb/tb_branch_resolve_unit.sv
module tb_branch_resolve_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  form = '0;
    logic [31:0] instr = '0, pc = '0, ctr = '0, lr = '0, cr = '0;
    logic        out_valid, taken, lr_wr;
    logic [31:0] next_addr, ctr_out, lr_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        logic        tk;
        logic [31:0] nxt;
        logic [31:0] c;
        logic [31:0] l;
        logic        lw;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    branch_resolve_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .form(form),
        .instr(instr), .pc(pc), .ctr(ctr), .lr(lr), .cr(cr),
        .out_valid(out_valid), .taken(taken), .next_addr(next_addr),
        .ctr_out(ctr_out), .lr_out(lr_out), .lr_wr(lr_wr)
    );

    // reference from the requirements
    function automatic exp_t model(input logic [2:0] f, input logic [31:0] iw,
                                   input logic [31:0] p, input logic [31:0] c,
                                   input logic [31:0] l, input logic [31:0] crv,
                                   input string tag);
        exp_t e;
        logic [4:0]  o  = iw[25:21];
        logic [4:0]  bi = iw[20:16];
        logic [31:0] d  = {{16{iw[15]}}, iw[15:2], 2'b00};
        logic [31:0] cn = c;
        logic cok, qok;
        logic [31:0] t;
        if (!o[2] && f[2:1] != 2'd2) cn = c - 32'd1;
        cok = o[2] || f[2:1] == 2'd2 || ((cn != 0) != o[1]);
        qok = o[4] || (crv[31 - bi] == o[3]);
        case (f[2:1])
            2'd0: t = p + d;
            2'd1: t = d;
            2'd2: t = {c[31:2], 2'b00};
            default: t = {l[31:2], 2'b00};
        endcase
        e.tk  = cok && qok;
        e.nxt = e.tk ? t : p + 32'd4;
        e.c   = cn;
        e.l   = f[0] ? p + 32'd4 : l;
        e.lw  = f[0];
        e.tag = tag;
        return e;
    endfunction

    function automatic logic [31:0] mk(input logic [4:0] o, input logic [4:0] bi,
                                       input logic [15:0] d);
        return {6'd16, o, bi, d};
    endfunction

    // driver: one request per call, back-to-back
    task automatic issue(input logic [2:0] f, input logic [31:0] iw,
                         input logic [31:0] p, input logic [31:0] c,
                         input logic [31:0] l, input logic [31:0] crv,
                         input string tag);
        @(negedge clk);
        in_valid = 1'b1; form = f; instr = iw; pc = p; ctr = c; lr = l; cr = crv;
        sb.push_back(model(f, iw, p, c, l, crv, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: pops and compares each result
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t e;
            tests++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R12: unexpected result, got out_valid=1 exp no result");
            end else begin
                e = sb.pop_front();
                if (taken !== e.tk || next_addr !== e.nxt || ctr_out !== e.c ||
                    lr_out !== e.l || lr_wr !== e.lw) begin
                    fails++;
                    $display("FAIL %s: got tk=%0b nxt=%h ctr=%h lr=%h lw=%0b exp tk=%0b nxt=%h ctr=%h lr=%h lw=%0b",
                             e.tag, taken, next_addr, ctr_out, lr_out, lr_wr,
                             e.tk, e.nxt, e.c, e.l, e.lw);
                end
            end
        end
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tests++;
        if (out_valid !== 0 || taken !== 0 || lr_wr !== 0 || next_addr !== 0 ||
            ctr_out !== 0 || lr_out !== 0) begin
            fails++;
            $display("FAIL R1: got v=%0b t=%0b nxt=%h ctr=%h lr=%h exp all zero",
                     out_valid, taken, next_addr, ctr_out, lr_out);
        end
        rst_n = 1'b1;

        // R2 relative: positive, negative, low bits masked
        issue(3'b000, mk(5'h14, 0, 16'h0010), 32'h1000, 32'd7, 32'h2000, 0, "R2");
        issue(3'b000, mk(5'h14, 0, 16'hFFF0), 32'h1000, 32'd7, 32'h2000, 0, "R2");
        issue(3'b000, mk(5'h14, 0, 16'h0013), 32'h1000, 32'd7, 32'h2000, 0, "R2");
        // R5 condition bit, MSB-first numbering and polarity
        issue(3'b000, mk(5'h0C, 5'd0,  16'h0040), 32'h3000, 0, 0, 32'h8000_0000, "R5");
        issue(3'b000, mk(5'h0C, 5'd1,  16'h0040), 32'h3000, 0, 0, 32'h8000_0000, "R5");
        issue(3'b000, mk(5'h0C, 5'd31, 16'h0040), 32'h3000, 0, 0, 32'h0000_0001, "R5");
        issue(3'b000, mk(5'h04, 5'd31, 16'h0040), 32'h3000, 0, 0, 32'h0000_0001, "R5");
        issue(3'b000, mk(5'h04, 5'd0,  16'h0040), 32'h3000, 0, 0, 32'h0000_0001, "R5");
        // R3/R4 decrement and count polarity, wrap from zero
        issue(3'b000, mk(5'h10, 0, 16'h0100), 32'h4000, 32'd1, 0, 0, "R4");
        issue(3'b000, mk(5'h10, 0, 16'h0100), 32'h4000, 32'd2, 0, 0, "R4");
        issue(3'b000, mk(5'h12, 0, 16'h0100), 32'h4000, 32'd1, 0, 0, "R4");
        issue(3'b000, mk(5'h12, 0, 16'h0100), 32'h4000, 32'd3, 0, 0, "R4");
        issue(3'b000, mk(5'h10, 0, 16'h0100), 32'h4000, 32'd0, 0, 0, "R3");
        issue(3'b000, mk(5'h14, 0, 16'h0100), 32'h4000, 32'd9, 0, 0, "R3");
        // R6 both tests must pass
        issue(3'b000, mk(5'h00, 5'd2, 16'h0100), 32'h5000, 32'd5, 0, 32'h2000_0000, "R6");
        issue(3'b000, mk(5'h00, 5'd2, 16'h0100), 32'h5000, 32'd5, 0, 32'h0000_0000, "R6");
        issue(3'b000, mk(5'h00, 5'd2, 16'h0100), 32'h5000, 32'd1, 0, 32'h0000_0000, "R6");
        // R7 absolute
        issue(3'b010, mk(5'h14, 0, 16'hFF00), 32'h6000, 32'd4, 0, 0, "R7");
        issue(3'b010, mk(5'h14, 0, 16'h0203), 32'h6000, 32'd4, 0, 0, "R7");
        // R8 count-target form
        issue(3'b100, mk(5'h10, 0, 0), 32'h7000, 32'd1, 0, 0, "R8");
        issue(3'b100, mk(5'h02, 0, 0), 32'h7000, 32'h0000_8887, 0, 32'h8000_0000, "R8");
        issue(3'b100, mk(5'h0C, 5'd3, 0), 32'h7000, 32'h0000_8887, 0, 0, "R8");
        // R9 link-target form
        issue(3'b110, mk(5'h14, 0, 0), 32'h8000, 32'd3, 32'h0000_ABCE, 0, "R9");
        issue(3'b110, mk(5'h10, 0, 0), 32'h8000, 32'd1, 32'h0000_ABCE, 0, "R9");
        issue(3'b110, mk(5'h10, 0, 0), 32'h8000, 32'd6, 32'h0000_ABCE, 0, "R9");
        // R10 linking variants, taken and not taken
        issue(3'b001, mk(5'h14, 0, 16'h0020), 32'h9000, 32'd2, 32'h1111_1110, 0, "R10");
        issue(3'b001, mk(5'h0C, 5'd4, 16'h0020), 32'h9000, 32'd2, 32'h1111_1110, 0, "R10");
        issue(3'b011, mk(5'h14, 0, 16'h0020), 32'h9000, 32'd2, 32'h1111_1110, 0, "R10");
        issue(3'b101, mk(5'h14, 0, 0), 32'h9000, 32'h0000_0C03, 32'h1111_1110, 0, "R10");
        // R11 linking link-target uses the old link value
        issue(3'b111, mk(5'h14, 0, 0), 32'hA000, 32'd2, 32'h0000_5557, 0, "R11");
        issue(3'b111, mk(5'h12, 0, 0), 32'hA000, 32'd1, 32'h0000_5557, 0, "R11");

        // R12 idle: no result, taken low
        idle();
        @(negedge clk);
        @(negedge clk);
        tests++;
        if (out_valid !== 0 || taken !== 0) begin
            fails++;
            $display("FAIL R12: idle got v=%0b t=%0b exp 0 0", out_valid, taken);
        end
        tests++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R12: %0d results missing, exp 0", sb.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R12: watchdog expired, got hang exp completion");
            summary();
            $finish;
        end
    end
endmodule